// File: doc/BRIEF.md
# Dual-Standard Raster Timing Generator

This block produces the raster timing for a composite-video graphics controller clocked at four times the colour subcarrier. A two-pin standard code selects NTSC/M, PAL or PAL/M. The block derives the subcarrier-rate clock by dividing the master clock by four. It runs the pixel and line counters and decodes from them the sync pulses, the active-video and blanking flags and the pixel stream that goes to the encoder.

For superimposing onto outside video, active-low external horizontal and vertical sync inputs pass through a synchroniser. On each falling edge they force the matching internal counter back to zero, which locks the raster to the foreign signal. A keying output tells the downstream video switch, per pixel, whether graphics or external video is shown. A colour-bar mode swaps the graphics input for eight equal-width bars. A line-select input chooses between the full and the short line count per field. An asynchronous reset and a synchronous initialise input both return the block to its start state.

Top module: `vid_timing_gen`

## Requirements
- R1: Standard code {std_a_i, std_b_i}: 11 and 10 select NTSC (std_o=0), 00 selects PAL (std_o=1), 01 selects PAL/M (std_o=2). PAL uses PAL_H_TOTAL clocks per line; NTSC and PAL/M use NTSC_H_TOTAL.
- R2: fsc_o is the clock divided by four. From reset or initialise it is low for two cycles and then high for two cycles, and this repeats.
- R3: h_cnt_o counts 0 to h_total-1 and wraps to 0. v_cnt_o increments on each wrap and returns to 0 after v_total-1.
- R4: line_sel_i=0 selects the full line count (NTSC_V_FULL / PAL_V_FULL). line_sel_i=1 selects the short count (NTSC_V_SHORT / PAL_V_SHORT).
- R5: A falling edge on ext_hs_ni makes h_cnt_o read 0 after the third rising clock edge. v_cnt_o is left unchanged. A low level held after the edge has no further effect.
- R6: A falling edge on ext_vs_ni makes v_cnt_o read 0 after the third rising clock edge. h_cnt_o keeps counting.
- R7: hsync_no is low exactly while h_cnt_o < H_SYNC_W. vsync_no is low exactly while v_cnt_o < V_SYNC_LINES.
- R8: active_o is high exactly when H_ACT_START <= h < h_total-H_FRONT and V_ACT_START <= v < v_total-V_BOTTOM. blank_o is its inverse.
- R9: pix_o is 0 outside active video. With bar_en_i low it equals gfx_pix_i inside active video.
- R10: With bar_en_i high, pix_o inside active video is min((h-H_ACT_START)/w, 7), where w = (h_total-H_FRONT-H_ACT_START)>>3.
- R11: key_o is high exactly when sup_en_i is high, active_o is high and pix_o is nonzero (pixel value 0 is transparent).
- R12: rst_ni low (asynchronous) or init_ni low at a clock edge clears both counters and fsc_o, and returns the sync inputs' pipelines to the idle-high state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4·fsc master clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| init_ni | input | 1 | synchronous initialise, active low |
| std_a_i | input | 1 | standard code, first bit |
| std_b_i | input | 1 | standard code, second bit |
| line_sel_i | input | 1 | 1 selects the short line count |
| ext_hs_ni | input | 1 | external horizontal sync, active low |
| ext_vs_ni | input | 1 | external vertical sync, active low |
| sup_en_i | input | 1 | superimpose enable |
| bar_en_i | input | 1 | colour-bar mode |
| gfx_pix_i | input | 4 | graphics palette index |
| fsc_o | output | 1 | subcarrier-rate clock |
| std_o | output | 2 | decoded standard |
| h_cnt_o | output | HW | pixel counter |
| v_cnt_o | output | VW | line counter |
| hsync_no | output | 1 | horizontal sync, active low |
| vsync_no | output | 1 | vertical sync, active low |
| active_o | output | 1 | active-video flag |
| blank_o | output | 1 | blanking flag |
| pix_o | output | 4 | pixel index to encoder |
| key_o | output | 1 | 1 shows graphics, 0 shows external video |

## Verification
The bench uses a shrunken raster. It sweeps all four standard codes with both line counts over whole frames and compares every output in every cycle against an arithmetic model. This exposes a wrong standard decode or a wrap that is off by one: the lines come out too long or too short. Directed external sync edges check the three-edge latency and the single reset per edge. A design that retriggered while the input stayed low would hold h_cnt_o at zero. The narrow PAL active width gives bars two pixels wide and the NTSC width leaves a remainder, so a bar counter that fails to saturate at 7 or mis-sizes the width shows up at once. A mid-line asynchronous reset and initialise pulses confirm that fsc_o restarts its low phase.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_PAL  = 2'd1,
    STD_PALM = 2'd2
  } vtg_std_e;

  localparam int unsigned BAR_COUNT = 8;
  localparam int unsigned BIDX_W    = $clog2(BAR_COUNT);
endpackage

// File: rtl/vtg_std_decode.sv
module vtg_std_decode
  import vtg_pkg::*;
#(
  parameter int unsigned NTSC_H_TOTAL = 910,
  parameter int unsigned PAL_H_TOTAL  = 1135,
  parameter int unsigned NTSC_V_FULL  = 525,
  parameter int unsigned NTSC_V_SHORT = 262,
  parameter int unsigned PAL_V_FULL   = 625,
  parameter int unsigned PAL_V_SHORT  = 312,
  parameter int unsigned HW           = 11,
  parameter int unsigned VW           = 10
) (
  input  logic          std_a_i,
  input  logic          std_b_i,
  input  logic          line_sel_i,
  output vtg_std_e      std_o,
  output logic [HW-1:0] h_total_o,
  output logic [VW-1:0] v_total_o
);
  always_comb begin
    unique case ({std_a_i, std_b_i})
      2'b00:   std_o = STD_PAL;
      2'b01:   std_o = STD_PALM;
      default: std_o = STD_NTSC;
    endcase
    if (std_o == STD_PAL) begin
      h_total_o = HW'(PAL_H_TOTAL);
      v_total_o = line_sel_i ? VW'(PAL_V_SHORT) : VW'(PAL_V_FULL);
    end else begin
      h_total_o = HW'(NTSC_H_TOTAL);
      v_total_o = line_sel_i ? VW'(NTSC_V_SHORT) : VW'(NTSC_V_FULL);
    end
  end
endmodule

// File: rtl/vtg_sync_edge.sv
module vtg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_ni,
  input  logic sync_ni,
  output logic fall_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '1;
    else if (!init_ni) sh_q <= '1;
    else               sh_q <= {sh_q[STAGES-1:0], sync_ni};
  end

  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/vtg_fsc_div.sv
module vtg_fsc_div (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_ni,
  output logic fsc_o
);
  logic [1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= '0;
    else if (!init_ni) ph_q <= '0;
    else               ph_q <= ph_q + 2'd1;
  end

  assign fsc_o = ph_q[1];
endmodule

// File: rtl/vtg_raster_cnt.sv
module vtg_raster_cnt #(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_ni,
  input  logic [HW-1:0] h_total_i,
  input  logic [VW-1:0] v_total_i,
  input  logic          h_rst_i,
  input  logic          v_rst_i,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o,
  output logic [HW-1:0] h_next_o
);
  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          h_wrap;

  always_comb begin
    h_wrap = h_q >= (h_total_i - 1'b1);
    h_d    = (h_rst_i || h_wrap) ? '0 : h_q + 1'b1;
    if (v_rst_i)                 v_d = '0;
    else if (h_wrap && !h_rst_i) v_d = (v_q >= (v_total_i - 1'b1)) ? '0 : v_q + 1'b1;
    else                         v_d = v_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (!init_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_cnt_o  = h_q;
  assign v_cnt_o  = v_q;
  assign h_next_o = init_ni ? h_d : '0;
endmodule

// File: rtl/vtg_bar_gen.sv
module vtg_bar_gen
  import vtg_pkg::*;
#(
  parameter int unsigned HW = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [HW-1:0]     bar_w_i,
  output logic [BIDX_W-1:0] idx_o
);
  localparam logic [BIDX_W-1:0] LAST = BIDX_W'(BAR_COUNT - 1);

  logic [HW-1:0]     cnt_q;
  logic [BIDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!init_ni || start_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (adv_i) begin
      if (cnt_q >= bar_w_i - 1'b1) begin
        cnt_q <= '0;
        if (idx_q != LAST) idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned NTSC_H_TOTAL = 910,
  parameter int unsigned PAL_H_TOTAL  = 1135,
  parameter int unsigned H_SYNC_W     = 67,
  parameter int unsigned H_ACT_START  = 160,
  parameter int unsigned H_FRONT      = 30,
  parameter int unsigned NTSC_V_FULL  = 525,
  parameter int unsigned NTSC_V_SHORT = 262,
  parameter int unsigned PAL_V_FULL   = 625,
  parameter int unsigned PAL_V_SHORT  = 312,
  parameter int unsigned V_SYNC_LINES = 3,
  parameter int unsigned V_ACT_START  = 20,
  parameter int unsigned V_BOTTOM     = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned H_MAX = (NTSC_H_TOTAL > PAL_H_TOTAL) ? NTSC_H_TOTAL : PAL_H_TOTAL,
  localparam int unsigned V_MAX = (NTSC_V_FULL > PAL_V_FULL) ? NTSC_V_FULL : PAL_V_FULL,
  localparam int unsigned HW    = $clog2(H_MAX + 1),
  localparam int unsigned VW    = $clog2(V_MAX + 1),
  localparam int unsigned PIX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_ni,
  input  logic             std_a_i,
  input  logic             std_b_i,
  input  logic             line_sel_i,
  input  logic             ext_hs_ni,
  input  logic             ext_vs_ni,
  input  logic             sup_en_i,
  input  logic             bar_en_i,
  input  logic [PIX_W-1:0] gfx_pix_i,
  output logic             fsc_o,
  output logic [1:0]       std_o,
  output logic [HW-1:0]    h_cnt_o,
  output logic [VW-1:0]    v_cnt_o,
  output logic             hsync_no,
  output logic             vsync_no,
  output logic             active_o,
  output logic             blank_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             key_o
);
  vtg_std_e          std;
  logic [HW-1:0]     h_total, h_next, h_end, bar_w;
  logic [VW-1:0]     v_total, v_end;
  logic [1:0]        ext_n, fall;
  logic              h_fall, v_fall;
  logic              h_act, v_act, bar_start, bar_adv;
  logic [BIDX_W-1:0] bar_idx;

  vtg_std_decode #(
    .NTSC_H_TOTAL(NTSC_H_TOTAL), .PAL_H_TOTAL(PAL_H_TOTAL),
    .NTSC_V_FULL(NTSC_V_FULL), .NTSC_V_SHORT(NTSC_V_SHORT),
    .PAL_V_FULL(PAL_V_FULL), .PAL_V_SHORT(PAL_V_SHORT),
    .HW(HW), .VW(VW)
  ) u_dec (
    .std_a_i(std_a_i), .std_b_i(std_b_i), .line_sel_i(line_sel_i),
    .std_o(std), .h_total_o(h_total), .v_total_o(v_total)
  );

  assign ext_n = {ext_vs_ni, ext_hs_ni};

  for (genvar g = 0; g < 2; g++) begin : g_ext
    vtg_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .init_ni(init_ni),
      .sync_ni(ext_n[g]), .fall_o(fall[g])
    );
  end

  assign h_fall = fall[0];
  assign v_fall = fall[1];

  vtg_fsc_div u_fsc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_ni(init_ni), .fsc_o(fsc_o)
  );

  vtg_raster_cnt #(.HW(HW), .VW(VW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_ni(init_ni),
    .h_total_i(h_total), .v_total_i(v_total),
    .h_rst_i(h_fall), .v_rst_i(v_fall),
    .h_cnt_o(h_cnt_o), .v_cnt_o(v_cnt_o), .h_next_o(h_next)
  );

  assign h_end = h_total - HW'(H_FRONT);
  assign v_end = v_total - VW'(V_BOTTOM);
  assign bar_w = (h_end - HW'(H_ACT_START)) >> BIDX_W;

  // bar state tracks the counter value that takes effect at the next edge
  assign bar_start = h_next == HW'(H_ACT_START);
  assign bar_adv   = (h_next > HW'(H_ACT_START)) && (h_next < h_end);

  vtg_bar_gen #(.HW(HW)) u_bar (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_ni(init_ni),
    .start_i(bar_start), .adv_i(bar_adv), .bar_w_i(bar_w), .idx_o(bar_idx)
  );

  always_comb begin
    h_act    = (h_cnt_o >= HW'(H_ACT_START)) && (h_cnt_o < h_end);
    v_act    = (v_cnt_o >= VW'(V_ACT_START)) && (v_cnt_o < v_end);
    active_o = h_act && v_act;
    blank_o  = !h_act || !v_act;
    hsync_no = h_cnt_o >= HW'(H_SYNC_W);
    vsync_no = v_cnt_o >= VW'(V_SYNC_LINES);
    if (!active_o)     pix_o = '0;
    else if (bar_en_i) pix_o = PIX_W'(bar_idx);
    else               pix_o = gfx_pix_i;
    key_o    = sup_en_i && active_o && (pix_o != '0);
  end

  assign std_o = std;
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int unsigned HW = 11,
  parameter int unsigned VW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_ni,
  input logic          h_fall_i,
  input logic          v_fall_i,
  input logic [HW-1:0] h_cnt_i,
  input logic [VW-1:0] v_cnt_i,
  input logic          fsc_i
);
  assert_hrst_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_fall_i |=> (h_cnt_i == '0));

  assert_hrst_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_fall_i |=> !h_fall_i);

  assert_vrst_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_fall_i |=> (v_cnt_i == '0));

  assert_vrst_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_fall_i |=> !v_fall_i);

  assert_line_step_at_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_ni) && !$past(v_fall_i) && (v_cnt_i != $past(v_cnt_i))) |-> (h_cnt_i == '0));

  assert_fsc_two_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(init_ni) && (fsc_i != $past(fsc_i))) |=> (!$past(init_ni) || (fsc_i == $past(fsc_i))));
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_ni(init_ni),
  .h_fall_i(h_fall), .v_fall_i(v_fall),
  .h_cnt_i(h_cnt_o), .v_cnt_i(v_cnt_o), .fsc_i(fsc_o)
);

// File: tb/vid_timing_gen_bench.sv
`timescale 1ns/1ps
module vid_timing_gen_bench;
  localparam int HT_N = 20, HT_P = 24, HSW = 3, HAS = 5, HF = 2;
  localparam int VF_N = 9, VS_N = 5, VF_P = 11, VS_P = 6;
  localparam int VSL = 1, VAS = 2, VB = 1;
  localparam int HW = $clog2(HT_P + 1);
  localparam int VW = $clog2(VF_P + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0, init_n = 1'b1;
  logic std_a = 1'b1, std_b = 1'b1, line_sel = 1'b0;
  logic ext_hs_n = 1'b1, ext_vs_n = 1'b1, sup_en = 1'b0, bar_en = 1'b0;
  logic [3:0] gfx = '0;
  logic fsc, hs_n, vs_n, act, blank, key;
  logic [1:0] std;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic [3:0] pix;

  int checks = 0, errors = 0, cyc = 0;
  int mh, mv, mq;
  bit s1h, s2h, pvh, s1v, s2v, pvv;

  always #4 clk = ~clk;

  vid_timing_gen #(
    .NTSC_H_TOTAL(HT_N), .PAL_H_TOTAL(HT_P), .H_SYNC_W(HSW), .H_ACT_START(HAS),
    .H_FRONT(HF), .NTSC_V_FULL(VF_N), .NTSC_V_SHORT(VS_N), .PAL_V_FULL(VF_P),
    .PAL_V_SHORT(VS_P), .V_SYNC_LINES(VSL), .V_ACT_START(VAS), .V_BOTTOM(VB)
  ) u_vid_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .init_ni(init_n), .std_a_i(std_a), .std_b_i(std_b),
    .line_sel_i(line_sel), .ext_hs_ni(ext_hs_n), .ext_vs_ni(ext_vs_n),
    .sup_en_i(sup_en), .bar_en_i(bar_en), .gfx_pix_i(gfx),
    .fsc_o(fsc), .std_o(std), .h_cnt_o(hc), .v_cnt_o(vc), .hsync_no(hs_n),
    .vsync_no(vs_n), .active_o(act), .blank_o(blank), .pix_o(pix), .key_o(key)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, actual, expected, cyc);
    end
  endtask

  function automatic int exp_std();
    if (!std_a && !std_b) return 1;
    if (!std_a && std_b) return 2;
    return 0;
  endfunction

  function automatic int h_tot();
    return (exp_std() == 1) ? HT_P : HT_N;
  endfunction

  function automatic int v_tot();
    if (exp_std() == 1) return line_sel ? VS_P : VF_P;
    return line_sel ? VS_N : VF_N;
  endfunction

  task automatic model_reset();
    mh = 0; mv = 0; mq = 0;
    s1h = 1; s2h = 1; pvh = 1; s1v = 1; s2v = 1; pvv = 1;
  endtask

  task automatic model_edge();
    bit hp, vp, wrap;
    int nh, nv;
    if (!rst_n) return;
    if (!init_n) begin
      model_reset();
      return;
    end
    hp = pvh && !s2h;
    vp = pvv && !s2v;
    wrap = mh >= h_tot() - 1;
    nh = (hp || wrap) ? 0 : mh + 1;
    if (vp) nv = 0;
    else if (wrap && !hp) nv = (mv >= v_tot() - 1) ? 0 : mv + 1;
    else nv = mv;
    mh = nh; mv = nv;
    pvh = s2h; s2h = s1h; s1h = ext_hs_n;
    pvv = s2v; s2v = s1v; s1v = ext_vs_n;
    mq = (mq + 1) % 4;
  endtask

  task automatic check_all();
    int he, bw, e_act, e_pix, bi;
    he = h_tot() - HF;
    bw = (he - HAS) >> 3;
    e_act = (mh >= HAS && mh < he && mv >= VAS && mv < v_tot() - VB) ? 1 : 0;
    if (!e_act) e_pix = 0;
    else if (bar_en) begin
      bi = (mh - HAS) / bw;
      e_pix = (bi > 7) ? 7 : bi;
    end else e_pix = gfx;
    check("R1", std, exp_std());
    check("R3 R5 R1", hc, mh);
    check("R3 R4 R6", vc, mv);
    check("R2", fsc, (mq >> 1) & 1);
    check("R7 hsync", hs_n, (mh >= HSW) ? 1 : 0);
    check("R7 vsync", vs_n, (mv >= VSL) ? 1 : 0);
    check("R8 active", act, e_act);
    check("R8 blank", blank, 1 - e_act);
    check(bar_en ? "R10" : "R9", pix, e_pix);
    check("R11", key, (sup_en && e_act && e_pix != 0) ? 1 : 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    check_all();
  endtask

  task automatic do_init();
    init_n = 1'b0;
    step();
    check("R12 init h", hc, 0);
    check("R12 init fsc", fsc, 0);
    init_n = 1'b1;
  endtask

  initial begin
    model_reset();
    #20;
    check("R12 reset h", hc, 0);
    check("R12 reset v", vc, 0);
    check("R12 reset fsc", fsc, 0);
    check("R12 reset hsync", hs_n, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // full sweep of standard codes and line counts
    for (int c = 0; c < 4; c++) begin
      for (int ls = 0; ls < 2; ls++) begin
        std_a = c[1]; std_b = c[0]; line_sel = ls[0];
        sup_en = ls[0] ^ c[0]; bar_en = c[1];
        do_init();
        for (int n = 0; n < 2 * h_tot() * v_tot() + 5; n++) begin
          gfx = 4'((cyc * 5) & 15);
          step();
        end
        // phase with external syncs toggling
        bar_en = ~bar_en;
        for (int n = 0; n < 300; n++) begin
          gfx = 4'((cyc * 3) & 15);
          ext_hs_n = !((n % 37) >= 11 && (n % 37) <= 14);
          ext_vs_n = !((n % 151) >= 50 && (n % 151) <= 55);
          step();
        end
        ext_hs_n = 1'b1; ext_vs_n = 1'b1;
        for (int n = 0; n < 4; n++) step();
      end
    end

    // directed R5: three-edge latency, no retrigger while held low
    std_a = 1'b1; std_b = 1'b1; line_sel = 1'b0;
    do_init();
    for (int n = 0; n < 7; n++) step();
    check("R5 pre", hc, 7);
    ext_hs_n = 1'b0;
    for (int n = 0; n < 3; n++) step();
    check("R5 latency", hc, 0);
    for (int n = 0; n < 10; n++) step();
    check("R5 held low", hc, 10);
    ext_hs_n = 1'b1;
    step();

    // directed R6: vertical reset leaves h counting
    for (int n = 0; n < 3 * HT_N; n++) step();
    ext_vs_n = 1'b0;
    for (int n = 0; n < 3; n++) step();
    check("R6 latency", vc, 0);
    check("R6 h keeps", hc, mh);
    ext_vs_n = 1'b1;
    for (int n = 0; n < 5; n++) step();

    // directed R12: asynchronous reset mid-line
    for (int n = 0; n < 6; n++) step();
    #1 rst_n = 1'b0;
    #1;
    model_reset();
    check("R12 async h", hc, 0);
    check("R12 async v", vc, 0);
    check("R12 async fsc", fsc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 8; n++) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule